// File: doc/BRIEF.md
# Parallel Pre-Trade Risk Checker

This block screens every outbound quote before it is released. A quote arrives as a single valid beat carrying an instrument index, a side (buy or sell), a limit price, a quantity and the current market reference price for that instrument. The index selects one row of an on-chip limit table. Each row holds an enable flag, a notional ceiling, a price band in percent, a quantity ceiling, a position ceiling, a tick step and a lot step, plus the instrument's current signed position. The host writes both the rows and the positions.

All rules are evaluated side by side in a four-register pipeline. The block accepts a new quote on every clock, and every quote yields exactly one verdict four cycles later. The verdict carries a six-bit reason mask with one bit per failed rule. It raises either a forward strobe, which releases the quote to the venue, or a reject strobe, which drops the quote and tells the trading application. Positions are not changed by the quotes themselves.

Top module: `pretrade_gate`

## Requirements
- R1: A quote sampled with `q_valid` high at clock edge n produces `d_valid` high for exactly the one cycle that follows edge n+3. A quote may enter on every cycle. `d_valid` stays low in cycles that no quote maps to.
- R2: Reason bit 1 is set when price × quantity is strictly greater than the row's notional ceiling.
- R3: Reason bit 2 is set when |price − reference| × 100 is strictly greater than band_percent × reference. The comparison uses no division.
- R4: Reason bit 3 is set when the quantity is strictly greater than the row's quantity ceiling.
- R5: The projected position is the stored position plus the quantity for a buy (`q_side`=0), or minus the quantity for a sell (`q_side`=1). Reason bit 4 is set when the absolute value of the projected position is strictly greater than the row's position ceiling. Negative positions are included.
- R6: Reason bit 5 is set when the price is not an exact multiple of the tick step, when the quantity is not an exact multiple of the lot step, or when either step is zero.
- R7: Reason bit 0 is set when the row's enable flag is clear. The other rules are still evaluated against the row's contents.
- R8: A quote whose reason mask is zero raises `fwd_strobe`. Any other quote raises `rej_strobe`. The two strobes are never high together, and both strobes and the mask are zero whenever `d_valid` is low.
- R9: A write with `cfg_we` high at edge w updates one field of row `cfg_inst`, chosen by `cfg_sel`: 0 enable flag (`cfg_data` bit 0), 1 notional ceiling, 2 band percent, 3 quantity ceiling, 4 position ceiling, 5 tick step, 6 lot step. A `pos_we` write replaces the row's position. A quote sampled at edge w sees the old value, and a quote sampled at edge w+1 sees the new value.
- R10: While `rst_n` is low, `d_valid`, the strobes and the mask are zero. After reset, every row is disabled, with all limits, steps and positions zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | Quote beat present |
| q_inst | input | IDX_W (4) | Instrument row index |
| q_side | input | 1 | 0 buy, 1 sell |
| q_price | input | PRICE_W (16) | Quote price in ticks of the base unit |
| q_qty | input | QTY_W (12) | Quote quantity |
| q_ref | input | PRICE_W (16) | Market reference price |
| cfg_we | input | 1 | Limit table write strobe |
| cfg_inst | input | IDX_W (4) | Row to write |
| cfg_sel | input | 3 | Field select (see R9) |
| cfg_data | input | NOT_W (28) | Field value, low bits used |
| pos_we | input | 1 | Position write strobe |
| pos_inst | input | IDX_W (4) | Row whose position is written |
| pos_data | input | POS_W (24) | Signed position value |
| d_valid | output | 1 | Verdict present |
| d_reason | output | 6 | Failed-rule mask (bit per R2 to R7) |
| fwd_strobe | output | 1 | Quote approved and released |
| rej_strobe | output | 1 | Quote rejected and dropped |

## Verification
The checker assumes that `q_valid` is known and held low while reset is asserted, and that reset does not fall while a quote is in flight. Its latency property relies on both. The strobe and mask properties rely only on the verdict registers. The stimulus raises reset once, at the start, with every input driven to zero. It changes inputs only on falling clock edges and sends quotes only after reset has been released. Because each quote is a single beat, a back-to-back stream produces one verdict per cycle with no gaps for the properties to miss.

// File: rtl/risk_pkg.sv
package risk_pkg;

   localparam int NUM_RULES  = 6;
   localparam int RB_OFFROW  = 0;
   localparam int RB_NOTION  = 1;
   localparam int RB_BAND    = 2;
   localparam int RB_QTYCAP  = 3;
   localparam int RB_POSCAP  = 4;
   localparam int RB_STEP    = 5;

   localparam int BAND_SCALE = 100;

   typedef enum logic [2:0] {
      FLD_ENABLE  = 3'd0,
      FLD_NOTION  = 3'd1,
      FLD_BANDPCT = 3'd2,
      FLD_QTYCAP  = 3'd3,
      FLD_POSCAP  = 3'd4,
      FLD_TICK    = 3'd5,
      FLD_LOT     = 3'd6
   } cfg_field_e;

endpackage

// File: rtl/pretrade_tbl.sv
module pretrade_tbl import risk_pkg::*; #(
   parameter int NUM_INST = 16,
   parameter int IDX_W    = 4,
   parameter int PRICE_W  = 16,
   parameter int QTY_W    = 12,
   parameter int POS_W    = 24,
   parameter int PCT_W    = 8,
   parameter int NOT_W    = 28
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [IDX_W-1:0]         cfg_inst,
   input  logic [2:0]               cfg_sel,
   input  logic [NOT_W-1:0]         cfg_data,
   input  logic                     pos_we,
   input  logic [IDX_W-1:0]         pos_inst,
   input  logic signed [POS_W-1:0]  pos_data,
   input  logic [IDX_W-1:0]         rd_inst,
   output logic                     rd_enable,
   output logic [NOT_W-1:0]         rd_notion,
   output logic [PCT_W-1:0]         rd_band,
   output logic [QTY_W-1:0]         rd_qtycap,
   output logic [POS_W-1:0]         rd_poscap,
   output logic [PRICE_W-1:0]       rd_tick,
   output logic [QTY_W-1:0]         rd_lot,
   output logic signed [POS_W-1:0]  rd_pos
);

   logic                    en_a     [NUM_INST];
   logic [NOT_W-1:0]        notion_a [NUM_INST];
   logic [PCT_W-1:0]        band_a   [NUM_INST];
   logic [QTY_W-1:0]        qcap_a   [NUM_INST];
   logic [POS_W-1:0]        pcap_a   [NUM_INST];
   logic [PRICE_W-1:0]      tick_a   [NUM_INST];
   logic [QTY_W-1:0]        lot_a    [NUM_INST];
   logic signed [POS_W-1:0] pos_a    [NUM_INST];

   for (genvar e = 0; e < NUM_INST; e++) begin : g_row
      logic                    en_r;
      logic [NOT_W-1:0]        notion_r;
      logic [PCT_W-1:0]        band_r;
      logic [QTY_W-1:0]        qcap_r;
      logic [POS_W-1:0]        pcap_r;
      logic [PRICE_W-1:0]      tick_r;
      logic [QTY_W-1:0]        lot_r;
      logic signed [POS_W-1:0] pos_r;
      logic                    hit_cfg;
      logic                    hit_pos;

      assign hit_cfg = cfg_we && (cfg_inst == IDX_W'(e));
      assign hit_pos = pos_we && (pos_inst == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r     <= 1'b0;
            notion_r <= '0;
            band_r   <= '0;
            qcap_r   <= '0;
            pcap_r   <= '0;
            tick_r   <= '0;
            lot_r    <= '0;
         end else if (hit_cfg) begin
            case (cfg_field_e'(cfg_sel))
               FLD_ENABLE:  en_r     <= cfg_data[0];
               FLD_NOTION:  notion_r <= cfg_data;
               FLD_BANDPCT: band_r   <= cfg_data[PCT_W-1:0];
               FLD_QTYCAP:  qcap_r   <= cfg_data[QTY_W-1:0];
               FLD_POSCAP:  pcap_r   <= cfg_data[POS_W-1:0];
               FLD_TICK:    tick_r   <= cfg_data[PRICE_W-1:0];
               FLD_LOT:     lot_r    <= cfg_data[QTY_W-1:0];
               default: ;
            endcase
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pos_r <= '0;
         else if (hit_pos) pos_r <= pos_data;
      end

      assign en_a[e]     = en_r;
      assign notion_a[e] = notion_r;
      assign band_a[e]   = band_r;
      assign qcap_a[e]   = qcap_r;
      assign pcap_a[e]   = pcap_r;
      assign tick_a[e]   = tick_r;
      assign lot_a[e]    = lot_r;
      assign pos_a[e]    = pos_r;
   end

   assign rd_enable = en_a[rd_inst];
   assign rd_notion = notion_a[rd_inst];
   assign rd_band   = band_a[rd_inst];
   assign rd_qtycap = qcap_a[rd_inst];
   assign rd_poscap = pcap_a[rd_inst];
   assign rd_tick   = tick_a[rd_inst];
   assign rd_lot    = lot_a[rd_inst];
   assign rd_pos    = pos_a[rd_inst];

endmodule

// File: rtl/pretrade_arith.sv
module pretrade_arith import risk_pkg::*; #(
   parameter int PRICE_W   = 16,
   parameter int QTY_W     = 12,
   parameter int POS_W     = 24,
   parameter int PCT_W     = 8,
   parameter int NOT_W     = 28,
   parameter int POW2_STEP = 0,
   localparam int DEV_W    = PRICE_W + 7,
   localparam int BAND_W   = PRICE_W + PCT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_enable,
   input  logic                     in_side,
   input  logic [PRICE_W-1:0]       in_price,
   input  logic [QTY_W-1:0]         in_qty,
   input  logic [PRICE_W-1:0]       in_ref,
   input  logic [NOT_W-1:0]         in_notion,
   input  logic [PCT_W-1:0]         in_band,
   input  logic [QTY_W-1:0]         in_qtycap,
   input  logic [POS_W-1:0]         in_poscap,
   input  logic [PRICE_W-1:0]       in_tick,
   input  logic [QTY_W-1:0]         in_lot,
   input  logic signed [POS_W-1:0]  in_pos,
   output logic                     out_valid,
   output logic                     out_offrow,
   output logic [NOT_W-1:0]         out_value,
   output logic [NOT_W-1:0]         out_notion,
   output logic [DEV_W-1:0]         out_dev,
   output logic [BAND_W-1:0]        out_band,
   output logic [QTY_W-1:0]         out_qty,
   output logic [QTY_W-1:0]         out_qtycap,
   output logic [POS_W:0]           out_pos_abs,
   output logic [POS_W-1:0]         out_poscap,
   output logic                     out_step_bad
);

   logic [PRICE_W-1:0]      gap;
   logic [NOT_W-1:0]        value_c;
   logic [DEV_W-1:0]        dev_c;
   logic [BAND_W-1:0]       band_c;
   logic signed [POS_W:0]   pos_ext;
   logic signed [POS_W:0]   qty_ext;
   logic signed [POS_W:0]   proj;
   logic [POS_W:0]          proj_abs;
   logic                    tick_off;
   logic                    lot_off;
   logic                    step_bad_c;

   assign gap     = (in_price >= in_ref) ? (in_price - in_ref) : (in_ref - in_price);
   assign value_c = NOT_W'(in_price) * NOT_W'(in_qty);
   assign dev_c   = DEV_W'(gap) * DEV_W'(BAND_SCALE);
   assign band_c  = BAND_W'(in_band) * BAND_W'(in_ref);

   assign pos_ext  = {in_pos[POS_W-1], in_pos};
   assign qty_ext  = $signed({{(POS_W + 1 - QTY_W){1'b0}}, in_qty});
   assign proj     = in_side ? (pos_ext - qty_ext) : (pos_ext + qty_ext);
   assign proj_abs = proj[POS_W] ? $unsigned(-proj) : $unsigned(proj);

   if (POW2_STEP != 0) begin : g_step_mask
      assign tick_off = (in_price & (in_tick - 1'b1)) != '0;
      assign lot_off  = (in_qty & (in_lot - 1'b1)) != '0;
   end else begin : g_step_mod
      logic [PRICE_W-1:0] tick_div;
      logic [QTY_W-1:0]   lot_div;
      assign tick_div = (in_tick == '0) ? PRICE_W'(1) : in_tick;
      assign lot_div  = (in_lot == '0) ? QTY_W'(1) : in_lot;
      assign tick_off = (in_price % tick_div) != '0;
      assign lot_off  = (in_qty % lot_div) != '0;
   end

   assign step_bad_c = (in_tick == '0) || (in_lot == '0) || tick_off || lot_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         out_offrow   <= !in_enable;
         out_value    <= value_c;
         out_notion   <= in_notion;
         out_dev      <= dev_c;
         out_band     <= band_c;
         out_qty      <= in_qty;
         out_qtycap   <= in_qtycap;
         out_pos_abs  <= proj_abs;
         out_poscap   <= in_poscap;
         out_step_bad <= step_bad_c;
      end
   end

endmodule

// File: rtl/pretrade_judge.sv
module pretrade_judge import risk_pkg::*; #(
   parameter int PRICE_W   = 16,
   parameter int QTY_W     = 12,
   parameter int POS_W     = 24,
   parameter int PCT_W     = 8,
   parameter int NOT_W     = 28,
   localparam int DEV_W    = PRICE_W + 7,
   localparam int BAND_W   = PRICE_W + PCT_W,
   localparam int CMP_W    = (DEV_W > BAND_W) ? DEV_W : BAND_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_offrow,
   input  logic [NOT_W-1:0]      in_value,
   input  logic [NOT_W-1:0]      in_notion,
   input  logic [DEV_W-1:0]      in_dev,
   input  logic [BAND_W-1:0]     in_band,
   input  logic [QTY_W-1:0]      in_qty,
   input  logic [QTY_W-1:0]      in_qtycap,
   input  logic [POS_W:0]        in_pos_abs,
   input  logic [POS_W-1:0]      in_poscap,
   input  logic                  in_step_bad,
   output logic                  d_valid,
   output logic [NUM_RULES-1:0]  d_reason,
   output logic                  fwd_strobe,
   output logic                  rej_strobe
);

   logic [NUM_RULES-1:0] mask_c;
   logic [NUM_RULES-1:0] s3_mask;
   logic                 s3_valid;

   always_comb begin
      mask_c             = '0;
      mask_c[RB_OFFROW]  = in_offrow;
      mask_c[RB_NOTION]  = in_value > in_notion;
      mask_c[RB_BAND]    = CMP_W'(in_dev) > CMP_W'(in_band);
      mask_c[RB_QTYCAP]  = in_qty > in_qtycap;
      mask_c[RB_POSCAP]  = in_pos_abs > {1'b0, in_poscap};
      mask_c[RB_STEP]    = in_step_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_valid <= 1'b0;
         s3_mask  <= '0;
      end else begin
         s3_valid <= in_valid;
         s3_mask  <= in_valid ? mask_c : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_valid    <= 1'b0;
         d_reason   <= '0;
         fwd_strobe <= 1'b0;
         rej_strobe <= 1'b0;
      end else begin
         d_valid    <= s3_valid;
         d_reason   <= s3_valid ? s3_mask : '0;
         fwd_strobe <= s3_valid && (s3_mask == '0);
         rej_strobe <= s3_valid && (s3_mask != '0);
      end
   end

endmodule

// File: rtl/pretrade_gate.sv
module pretrade_gate import risk_pkg::*; #(
   parameter int  NUM_INST  = 16,
   parameter int  PRICE_W   = 16,
   parameter int  QTY_W     = 12,
   parameter int  POS_W     = 24,
   parameter int  PCT_W     = 8,
   parameter int  POW2_STEP = 0,
   localparam int IDX_W     = (NUM_INST > 1) ? $clog2(NUM_INST) : 1,
   localparam int NOT_W     = PRICE_W + QTY_W,
   localparam int DEV_W     = PRICE_W + 7,
   localparam int BAND_W    = PRICE_W + PCT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     q_valid,
   input  logic [IDX_W-1:0]         q_inst,
   input  logic                     q_side,
   input  logic [PRICE_W-1:0]       q_price,
   input  logic [QTY_W-1:0]         q_qty,
   input  logic [PRICE_W-1:0]       q_ref,
   input  logic                     cfg_we,
   input  logic [IDX_W-1:0]         cfg_inst,
   input  logic [2:0]               cfg_sel,
   input  logic [NOT_W-1:0]         cfg_data,
   input  logic                     pos_we,
   input  logic [IDX_W-1:0]         pos_inst,
   input  logic signed [POS_W-1:0]  pos_data,
   output logic                     d_valid,
   output logic [NUM_RULES-1:0]     d_reason,
   output logic                     fwd_strobe,
   output logic                     rej_strobe
);

   if (NUM_INST < 2 || (1 << IDX_W) != NUM_INST) begin : g_bad_inst
      $error("pretrade_gate: NUM_INST must be a power of two of at least 2");
   end
   if (PRICE_W < 8) begin : g_bad_price
      $error("pretrade_gate: PRICE_W must be at least 8");
   end
   if (QTY_W >= POS_W) begin : g_bad_qty
      $error("pretrade_gate: QTY_W must be narrower than POS_W");
   end
   if (POS_W > NOT_W || PCT_W > NOT_W || PCT_W < 1) begin : g_bad_cfg
      $error("pretrade_gate: configuration fields must fit in cfg_data");
   end

   logic                    t_enable;
   logic [NOT_W-1:0]        t_notion;
   logic [PCT_W-1:0]        t_band;
   logic [QTY_W-1:0]        t_qtycap;
   logic [POS_W-1:0]        t_poscap;
   logic [PRICE_W-1:0]      t_tick;
   logic [QTY_W-1:0]        t_lot;
   logic signed [POS_W-1:0] t_pos;

   pretrade_tbl #(
      .NUM_INST (NUM_INST), .IDX_W (IDX_W), .PRICE_W (PRICE_W),
      .QTY_W (QTY_W), .POS_W (POS_W), .PCT_W (PCT_W), .NOT_W (NOT_W)
   ) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_inst  (cfg_inst),
      .cfg_sel   (cfg_sel),
      .cfg_data  (cfg_data),
      .pos_we    (pos_we),
      .pos_inst  (pos_inst),
      .pos_data  (pos_data),
      .rd_inst   (q_inst),
      .rd_enable (t_enable),
      .rd_notion (t_notion),
      .rd_band   (t_band),
      .rd_qtycap (t_qtycap),
      .rd_poscap (t_poscap),
      .rd_tick   (t_tick),
      .rd_lot    (t_lot),
      .rd_pos    (t_pos)
   );

   // stage 1: quote and its table row captured together
   logic                    s1_valid;
   logic                    s1_enable;
   logic                    s1_side;
   logic [PRICE_W-1:0]      s1_price;
   logic [QTY_W-1:0]        s1_qty;
   logic [PRICE_W-1:0]      s1_ref;
   logic [NOT_W-1:0]        s1_notion;
   logic [PCT_W-1:0]        s1_band;
   logic [QTY_W-1:0]        s1_qtycap;
   logic [POS_W-1:0]        s1_poscap;
   logic [PRICE_W-1:0]      s1_tick;
   logic [QTY_W-1:0]        s1_lot;
   logic signed [POS_W-1:0] s1_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= q_valid;
   end

   always_ff @(posedge clk) begin
      if (q_valid) begin
         s1_enable <= t_enable;
         s1_side   <= q_side;
         s1_price  <= q_price;
         s1_qty    <= q_qty;
         s1_ref    <= q_ref;
         s1_notion <= t_notion;
         s1_band   <= t_band;
         s1_qtycap <= t_qtycap;
         s1_poscap <= t_poscap;
         s1_tick   <= t_tick;
         s1_lot    <= t_lot;
         s1_pos    <= t_pos;
      end
   end

   // stage 2: products, projected position, step remainders
   logic               s2_valid;
   logic               s2_offrow;
   logic [NOT_W-1:0]   s2_value;
   logic [NOT_W-1:0]   s2_notion;
   logic [DEV_W-1:0]   s2_dev;
   logic [BAND_W-1:0]  s2_band;
   logic [QTY_W-1:0]   s2_qty;
   logic [QTY_W-1:0]   s2_qtycap;
   logic [POS_W:0]     s2_pos_abs;
   logic [POS_W-1:0]   s2_poscap;
   logic               s2_step_bad;

   pretrade_arith #(
      .PRICE_W (PRICE_W), .QTY_W (QTY_W), .POS_W (POS_W),
      .PCT_W (PCT_W), .NOT_W (NOT_W), .POW2_STEP (POW2_STEP)
   ) u_arith (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (s1_valid),
      .in_enable    (s1_enable),
      .in_side      (s1_side),
      .in_price     (s1_price),
      .in_qty       (s1_qty),
      .in_ref       (s1_ref),
      .in_notion    (s1_notion),
      .in_band      (s1_band),
      .in_qtycap    (s1_qtycap),
      .in_poscap    (s1_poscap),
      .in_tick      (s1_tick),
      .in_lot       (s1_lot),
      .in_pos       (s1_pos),
      .out_valid    (s2_valid),
      .out_offrow   (s2_offrow),
      .out_value    (s2_value),
      .out_notion   (s2_notion),
      .out_dev      (s2_dev),
      .out_band     (s2_band),
      .out_qty      (s2_qty),
      .out_qtycap   (s2_qtycap),
      .out_pos_abs  (s2_pos_abs),
      .out_poscap   (s2_poscap),
      .out_step_bad (s2_step_bad)
   );

   // stages 3 and 4: parallel compares, then verdict
   pretrade_judge #(
      .PRICE_W (PRICE_W), .QTY_W (QTY_W), .POS_W (POS_W),
      .PCT_W (PCT_W), .NOT_W (NOT_W)
   ) u_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (s2_valid),
      .in_offrow   (s2_offrow),
      .in_value    (s2_value),
      .in_notion   (s2_notion),
      .in_dev      (s2_dev),
      .in_band     (s2_band),
      .in_qty      (s2_qty),
      .in_qtycap   (s2_qtycap),
      .in_pos_abs  (s2_pos_abs),
      .in_poscap   (s2_poscap),
      .in_step_bad (s2_step_bad),
      .d_valid     (d_valid),
      .d_reason    (d_reason),
      .fwd_strobe  (fwd_strobe),
      .rej_strobe  (rej_strobe)
   );

endmodule

// File: rtl/pretrade_gate_chk.sv
module pretrade_gate_chk #(
   parameter int NRULE = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             q_valid,
   input logic             d_valid,
   input logic [NRULE-1:0] d_reason,
   input logic             fwd_strobe,
   input logic             rej_strobe
);

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ##4 d_valid); // R1

   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> ##4 !d_valid); // R1

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_strobe && rej_strobe)); // R8

   AST_FWD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_strobe |-> (d_reason == '0)); // R8

   AST_REJ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      rej_strobe |-> ($countones(d_reason) >= 1)); // R8

   AST_VERDICT_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (fwd_strobe || rej_strobe)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !d_valid |-> (!fwd_strobe && !rej_strobe && d_reason == '0)); // R8

endmodule

bind pretrade_gate pretrade_gate_chk #(.NRULE(risk_pkg::NUM_RULES)) u_chk (.*);

// File: tb/pretrade_gate_tb_top.sv
`timescale 1ns/1ps
module pretrade_gate_tb_top;

   typedef struct packed {
      logic [3:0]  inst;
      logic        side;
      logic [15:0] price;
      logic [11:0] qty;
      logic [15:0] rf;
      logic [5:0]  exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 1'b0, 16'd100, 12'd100,  16'd100, 6'b000000}, // R8 clean buy
      '{4'd0, 1'b0, 16'd120, 12'd100,  16'd100, 6'b000100}, // R3 outside band
      '{4'd0, 1'b0, 16'd110, 12'd100,  16'd100, 6'b000000}, // R3 band edge
      '{4'd0, 1'b0, 16'd105, 12'd1000, 16'd100, 6'b001010}, // R2 and R4
      '{4'd0, 1'b0, 16'd103, 12'd15,   16'd100, 6'b100000}, // R6 off tick and lot
      '{4'd1, 1'b1, 16'd50,  12'd100,  16'd50,  6'b000000}, // R5 sell shrinks
      '{4'd1, 1'b0, 16'd50,  12'd600,  16'd50,  6'b010000}, // R5 over ceiling
      '{4'd1, 1'b0, 16'd50,  12'd500,  16'd50,  6'b000000}, // R5 at ceiling
      '{4'd2, 1'b0, 16'd10,  12'd1,    16'd10,  6'b111011}, // R7 disabled row
      '{4'd1, 1'b1, 16'd40,  12'd100,  16'd50,  6'b000100}, // R3 below reference
      '{4'd0, 1'b1, 16'd95,  12'd500,  16'd100, 6'b000000}, // R4 at ceiling
      '{4'd0, 1'b0, 16'd100, 12'd510,  16'd100, 6'b001000}  // R4 over ceiling
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               q_valid = 1'b0;
   logic [3:0]         q_inst = '0;
   logic               q_side = 1'b0;
   logic [15:0]        q_price = '0;
   logic [11:0]        q_qty = '0;
   logic [15:0]        q_ref = '0;
   logic               cfg_we = 1'b0;
   logic [3:0]         cfg_inst = '0;
   logic [2:0]         cfg_sel = '0;
   logic [27:0]        cfg_data = '0;
   logic               pos_we = 1'b0;
   logic [3:0]         pos_inst = '0;
   logic signed [23:0] pos_data = '0;
   logic               d_valid;
   logic [5:0]         d_reason;
   logic               fwd_strobe;
   logic               rej_strobe;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pretrade_gate dut_i (
      .clk (clk), .rst_n (rst_n),
      .q_valid (q_valid), .q_inst (q_inst), .q_side (q_side),
      .q_price (q_price), .q_qty (q_qty), .q_ref (q_ref),
      .cfg_we (cfg_we), .cfg_inst (cfg_inst), .cfg_sel (cfg_sel), .cfg_data (cfg_data),
      .pos_we (pos_we), .pos_inst (pos_inst), .pos_data (pos_data),
      .d_valid (d_valid), .d_reason (d_reason),
      .fwd_strobe (fwd_strobe), .rej_strobe (rej_strobe)
   );

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [5:0] m);
      if (m == 6'd0) return "R8";
      if (m[0])      return "R7";
      if (m[1])      return "R2";
      if (m[2])      return "R3";
      if (m[3])      return "R4";
      if (m[4])      return "R5";
      return "R6";
   endfunction

   task automatic check_verdict(input string tag, input logic [5:0] exp);
      check("R1", {tag, " verdict present"}, longint'(d_valid), 1);
      check(tag, "reason mask", longint'(d_reason), longint'(exp));
      check("R8", {tag, " forward"}, longint'(fwd_strobe), longint'(exp == 6'd0));
      check("R8", {tag, " reject"}, longint'(rej_strobe), longint'(exp != 6'd0));
   endtask

   task automatic check_idle(input string tag);
      check(tag, "idle d_valid", longint'(d_valid), 0);
      check(tag, "idle strobes", longint'({fwd_strobe, rej_strobe}), 0);
      check(tag, "idle mask", longint'(d_reason), 0);
   endtask

   task automatic cfg_write(input logic [3:0] inst, input logic [2:0] sel, input logic [27:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_inst = inst; cfg_sel = sel; cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pos_write(input logic [3:0] inst, input logic signed [23:0] data);
      @(negedge clk);
      pos_we = 1'b1; pos_inst = inst; pos_data = data;
      @(negedge clk);
      pos_we = 1'b0;
   endtask

   task automatic set_quote(input vec_t v);
      q_valid = 1'b1; q_inst = v.inst; q_side = v.side;
      q_price = v.price; q_qty = v.qty; q_ref = v.rf;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R10: outputs quiet under reset
      repeat (3) @(negedge clk);
      check_idle("R10");
      rst_n = 1'b1;

      // R10: rows start disabled with zero contents
      @(negedge clk);
      set_quote('{4'd5, 1'b0, 16'd10, 12'd10, 16'd10, 6'd0});
      @(negedge clk);
      q_valid = 1'b0;
      repeat (3) @(negedge clk);
      check_verdict("R10", 6'b111011);

      // R9: program rows 0 and 1, position of row 1
      cfg_write(4'd0, 3'd1, 28'd100000);
      cfg_write(4'd0, 3'd2, 28'd10);
      cfg_write(4'd0, 3'd3, 28'd500);
      cfg_write(4'd0, 3'd4, 28'd1000);
      cfg_write(4'd0, 3'd5, 28'd5);
      cfg_write(4'd0, 3'd6, 28'd10);
      cfg_write(4'd0, 3'd0, 28'd1);
      cfg_write(4'd1, 3'd1, 28'd1000000);
      cfg_write(4'd1, 3'd2, 28'd5);
      cfg_write(4'd1, 3'd3, 28'd4000);
      cfg_write(4'd1, 3'd4, 28'd3000);
      cfg_write(4'd1, 3'd5, 28'd1);
      cfg_write(4'd1, 3'd6, 28'd1);
      cfg_write(4'd1, 3'd0, 28'd1);
      pos_write(4'd1, 24'sd2500);

      // streamed vectors, one per cycle, verdict four cycles later (R1)
      for (int i = 0; i < NV + 4; i++) begin
         @(negedge clk);
         if (i >= 4) check_verdict(tag_of(VECS[i-4].exp), VECS[i-4].exp);
         if (i < NV) set_quote(VECS[i]);
         else        q_valid = 1'b0;
      end
      @(negedge clk);
      check_idle("R1");

      // R9: write and quote on the same edge, then a quote one edge later
      @(negedge clk);
      cfg_we = 1'b1; cfg_inst = 4'd0; cfg_sel = 3'd3; cfg_data = 28'd50;
      set_quote('{4'd0, 1'b0, 16'd100, 12'd100, 16'd100, 6'd0});
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      q_valid = 1'b0;
      repeat (2) @(negedge clk);
      check_verdict("R9", 6'b000000);
      @(negedge clk);
      check_verdict("R9", 6'b001000);
      @(negedge clk);
      check_idle("R1");

      // R5: short position, sells push the magnitude up
      pos_write(4'd1, -24'sd2900);
      set_quote('{4'd1, 1'b1, 16'd50, 12'd200, 16'd50, 6'd0});
      @(negedge clk);
      set_quote('{4'd1, 1'b1, 16'd50, 12'd100, 16'd50, 6'd0});
      @(negedge clk);
      q_valid = 1'b0;
      repeat (2) @(negedge clk);
      check_verdict("R5", 6'b010000);
      @(negedge clk);
      check_verdict("R5", 6'b000000);

      // R7: disabling a row rejects with only the row bit on otherwise clean quote
      cfg_write(4'd1, 3'd0, 28'd0);
      set_quote('{4'd1, 1'b1, 16'd50, 12'd100, 16'd50, 6'd0});
      @(negedge clk);
      q_valid = 1'b0;
      repeat (3) @(negedge clk);
      check_verdict("R7", 6'b000001);

      summary();
      $finish;
   end

endmodule